// File: doc/BRIEF.md
# Deep Pipeline Hazard Interlock

This block decides, every cycle, whether the instruction in the register-read slot of a ten-stage in-order integer pipeline may advance into the first execute stage. The stage order is F1, F2, R1, X1, X2, X3, M1, M2, M3, W1. The execute group is X1 to X3 and the memory group is M1 to M3. An ALU or multiply result can first be forwarded once X3 has ended. A load result can first be forwarded once M3 has ended. A consumer needs its operands at the start of X1.

The block keeps a small shadow of producer tags, one per back-end stage from X1 to W1. Each tag holds a valid bit, a write flag, a load flag and a destination register. The front end presents the R1 instruction: its two sources, its destination, its write enable and its class. From these the block drives four kinds of output: a hold for F1, F2 and R1; a bubble indication for X1; a forward-select code for each operand; and a kill vector for the three front slots. Kill is raised when the branch in X1 resolves taken. Branches are predicted not-taken, so that case redirects fetch.

Top module: `hz_interlock`

## Requirements
- R1: After reset, and whenever no R1 instruction is valid, `front_hold` and `front_kill` are 0, `x1_bubble` is 1 and both forward codes are 0.
- R2: A consumer of an ALU result written `g` instructions or bubbles after its producer (g = 0 means directly behind) is held for max(0, 2 - g) cycles.
- R3: A consumer of a load result is held for max(0, 5 - g) cycles, and never for more than 5 consecutive cycles.
- R4: While `front_hold` is 1, `x1_bubble` is 1 and both forward codes are 0. In the cycle the consumer is released, `x1_bubble` is 0.
- R5: Forward codes are chosen separately for each operand, in the cycle the instruction advances, from where its youngest producer sits. The code is 0 when there is no producer (register file), 1 when the producer is in X3, M1 or M2, 2 when it is in M3, and 3 when it is in W1.
- R6: When several older instructions write the same source register, only the youngest one sets the hold and the forward code.
- R7: Source register 0 never matches. A producer with write enable clear, or with destination 0, never causes a hold or a nonzero code.
- R8: A taken resolution while X1 holds a valid instruction drives `front_kill` to 3'b111 (bit 2 F1, bit 1 F2, bit 0 R1). In the same cycle, hold and both codes are 0 and the bubble is 1. The killed R1 instruction never acts as a producer afterwards, and kill is 0 in the next cycle.
- R9: A taken resolution while X1 holds a bubble is ignored: `front_kill` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| r1_vld | input | 1 | R1 holds a valid instruction |
| r1_src_a | input | 5 | First source register of the R1 instruction |
| r1_src_b | input | 5 | Second source register of the R1 instruction |
| r1_dst | input | 5 | Destination register of the R1 instruction |
| r1_wen | input | 1 | R1 instruction writes its destination |
| r1_is_load | input | 1 | R1 instruction is a load (result ready after M3) |
| x1_br_taken | input | 1 | Branch in X1 resolved taken this cycle |
| front_hold | output | 1 | Hold F1, F2 and R1 |
| x1_bubble | output | 1 | X1 receives no instruction next cycle |
| fwd_a | output | 2 | Forward select for the first operand |
| fwd_b | output | 2 | Forward select for the second operand |
| front_kill | output | 3 | Clear valid of F1 (bit 2), F2 (bit 1), R1 (bit 0) |

## Verification
The assertions cover the relationships that hold on every cycle whatever the instruction stream:
- kill excludes hold, and kill is either all three slots or none;
- a hold always comes with a bubble and zero forward codes;
- no hold run is longer than the load latency;
- a kill is never followed by a second kill;
- a zero source always gets code 0.

Exact hold lengths for each producer class and separation, youngest-wins selection, the per-operand code values, and the absence of any effect from a killed instruction all depend on history. Only the bench's reference model and its directed scenarios can show those.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_AW      = 5;
    localparam int BACK_DEPTH  = 7;   // X1 X2 X3 M1 M2 M3 W1
    localparam int ALU_RDY     = 2;   // stage index of X3
    localparam int LOAD_RDY    = 5;   // stage index of M3
    localparam int FRONT_SLOTS = 3;   // R1 F2 F1
    localparam int NUM_OPS     = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef struct packed {
        logic     vld;
        logic     wr;
        logic     is_load;
        reg_idx_t dst;
    } tag_t;

    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_EXE = 2'd1,
        FWD_MEM = 2'd2,
        FWD_WB  = 2'd3
    } fwd_e;

    // A producer at back-end index idx can feed X1 next cycle.
    function automatic logic tag_ready(input int idx, input logic is_load,
                                       input int alu_rdy, input int load_rdy);
        return is_load ? (idx >= load_rdy) : (idx >= alu_rdy);
    endfunction

    // Source of the forwarded value for a producer at index idx.
    function automatic fwd_e fwd_for_index(input int idx, input int load_rdy,
                                           input int depth);
        if (idx < load_rdy)
            return FWD_EXE;
        else if (idx < depth - 1)
            return FWD_MEM;
        else
            return FWD_WB;
    endfunction

endpackage

// File: rtl/hz_tag_pipe.sv
module hz_tag_pipe
    import hz_pkg::*;
#(
    parameter int DEPTH = BACK_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  tag_t                  enter,
    output tag_t [DEPTH-1:0]      stages_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stages_q <= '0;
        end else begin
            stages_q[0] <= enter;
            for (int i = 1; i < DEPTH; i++) begin
                stages_q[i] <= stages_q[i-1];
            end
        end
    end

endmodule

// File: rtl/hz_dep_check.sv
module hz_dep_check
    import hz_pkg::*;
#(
    parameter int DEPTH    = BACK_DEPTH,
    parameter int ALU_AT   = ALU_RDY,
    parameter int LOAD_AT  = LOAD_RDY
) (
    input  reg_idx_t             src,
    input  tag_t [DEPTH-1:0]     stages,
    output logic                 hazard,
    output logic [1:0]           code
);

    // Scan oldest to youngest so the youngest match is applied last.
    always_comb begin
        hazard = 1'b0;
        code   = FWD_RF;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (stages[i].vld && stages[i].wr && (src != '0) &&
                (stages[i].dst == src)) begin
                if (tag_ready(i, stages[i].is_load, ALU_AT, LOAD_AT)) begin
                    hazard = 1'b0;
                    code   = fwd_for_index(i, LOAD_AT, DEPTH);
                end else begin
                    hazard = 1'b1;
                    code   = FWD_RF;
                end
            end
        end
    end

endmodule

// File: rtl/hz_front_ctl.sv
module hz_front_ctl
    import hz_pkg::*;
#(
    parameter int NOPS  = NUM_OPS,
    parameter int SLOTS = FRONT_SLOTS
) (
    input  logic                    r1_vld,
    input  logic                    br_taken,
    input  logic                    x1_vld,
    input  logic [NOPS-1:0]         op_haz,
    input  logic [NOPS-1:0][1:0]    op_code,
    output logic                    hold,
    output logic                    enter,
    output logic [SLOTS-1:0]        kill,
    output logic [NOPS-1:0][1:0]    fwd_out
);

    logic flush;

    // Flush wins over hold; a squashed R1 instruction raises nothing.
    assign flush = br_taken & x1_vld;
    assign hold  = r1_vld & ~flush & (|op_haz);
    assign enter = r1_vld & ~flush & ~hold;
    assign kill  = {SLOTS{flush}};

    for (genvar k = 0; k < NOPS; k++) begin : g_fwd
        assign fwd_out[k] = enter ? op_code[k] : FWD_RF;
    end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int DEPTH   = BACK_DEPTH,
    parameter int ALU_AT  = ALU_RDY,
    parameter int LOAD_AT = LOAD_RDY,
    parameter int SLOTS   = FRONT_SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              r1_vld,
    input  logic [4:0]        r1_src_a,
    input  logic [4:0]        r1_src_b,
    input  logic [4:0]        r1_dst,
    input  logic              r1_wen,
    input  logic              r1_is_load,
    input  logic              x1_br_taken,
    output logic              front_hold,
    output logic              x1_bubble,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic [SLOTS-1:0]  front_kill
);

    tag_t [DEPTH-1:0]          stages_q;
    tag_t                      enter_tag;
    logic                      enter;
    reg_idx_t [NUM_OPS-1:0]    srcs;
    logic [NUM_OPS-1:0]        op_haz;
    logic [NUM_OPS-1:0][1:0]   op_code;
    logic [NUM_OPS-1:0][1:0]   fwd_out;

    assign srcs[0] = r1_src_a;
    assign srcs[1] = r1_src_b;

    always_comb begin
        enter_tag = '0;
        if (enter) begin
            enter_tag.vld     = 1'b1;
            enter_tag.wr      = r1_wen & (r1_dst != '0);
            enter_tag.is_load = r1_is_load;
            enter_tag.dst     = r1_dst;
        end
    end

    hz_tag_pipe #(.DEPTH(DEPTH)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .enter    (enter_tag),
        .stages_q (stages_q)
    );

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        hz_dep_check #(
            .DEPTH   (DEPTH),
            .ALU_AT  (ALU_AT),
            .LOAD_AT (LOAD_AT)
        ) u_dep (
            .src    (srcs[k]),
            .stages (stages_q),
            .hazard (op_haz[k]),
            .code   (op_code[k])
        );
    end

    hz_front_ctl #(.NOPS(NUM_OPS), .SLOTS(SLOTS)) u_ctl (
        .r1_vld   (r1_vld),
        .br_taken (x1_br_taken),
        .x1_vld   (stages_q[0].vld),
        .op_haz   (op_haz),
        .op_code  (op_code),
        .hold     (front_hold),
        .enter    (enter),
        .kill     (front_kill),
        .fwd_out  (fwd_out)
    );

    assign x1_bubble = ~enter;
    assign fwd_a     = fwd_out[0];
    assign fwd_b     = fwd_out[1];

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
    parameter int LOAD_AT = hz_pkg::LOAD_RDY,
    parameter int SLOTS   = hz_pkg::FRONT_SLOTS
) (
    input logic              clk,
    input logic              rst,
    input logic              r1_vld,
    input logic [4:0]        r1_src_a,
    input logic [4:0]        r1_src_b,
    input logic              front_hold,
    input logic              x1_bubble,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b,
    input logic [SLOTS-1:0]  front_kill
);

    int unsigned hold_run;

    always_ff @(posedge clk) begin
        if (rst)
            hold_run <= 0;
        else if (front_hold)
            hold_run <= hold_run + 1;
        else
            hold_run <= 0;
    end

    // R8
    kill_blocks_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (front_kill != '0) |-> !front_hold);

    // R8
    kill_all_or_none_chk: assert property (@(posedge clk) disable iff (rst)
        (front_kill == '0) || (front_kill == {SLOTS{1'b1}}));

    // R8
    kill_not_repeated_chk: assert property (@(posedge clk) disable iff (rst)
        (front_kill != '0) |=> (front_kill == '0));

    // R4
    hold_gives_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        front_hold |-> (x1_bubble && fwd_a == 2'd0 && fwd_b == 2'd0));

    // R3
    hold_run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        front_hold |-> (hold_run < LOAD_AT));

    // R1
    idle_no_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !r1_vld |-> (!front_hold && x1_bubble));

    // R7
    zero_src_a_chk: assert property (@(posedge clk) disable iff (rst)
        (r1_src_a == 5'd0) |-> (fwd_a == 2'd0));

    // R7
    zero_src_b_chk: assert property (@(posedge clk) disable iff (rst)
        (r1_src_b == 5'd0) |-> (fwd_b == 2'd0));

endmodule

bind hz_interlock hz_interlock_chk #(.LOAD_AT(LOAD_AT), .SLOTS(SLOTS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .r1_vld     (r1_vld),
    .r1_src_a   (r1_src_a),
    .r1_src_b   (r1_src_b),
    .front_hold (front_hold),
    .x1_bubble  (x1_bubble),
    .fwd_a      (fwd_a),
    .fwd_b      (fwd_b),
    .front_kill (front_kill)
);

// File: tb/tb_hz_interlock.sv
`timescale 1ns/1ps
module tb_hz_interlock;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       r1_vld = 1'b0;
    logic [4:0] r1_src_a = '0, r1_src_b = '0, r1_dst = '0;
    logic       r1_wen = 1'b0, r1_is_load = 1'b0, x1_br_taken = 1'b0;
    logic       front_hold, x1_bubble;
    logic [1:0] fwd_a, fwd_b;
    logic [2:0] front_kill;

    hz_interlock dut (
        .clk(clk), .rst(rst), .r1_vld(r1_vld), .r1_src_a(r1_src_a),
        .r1_src_b(r1_src_b), .r1_dst(r1_dst), .r1_wen(r1_wen),
        .r1_is_load(r1_is_load), .x1_br_taken(x1_br_taken),
        .front_hold(front_hold), .x1_bubble(x1_bubble), .fwd_a(fwd_a),
        .fwd_b(fwd_b), .front_kill(front_kill)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            failures++;
            $display("FAIL R4 watchdog: actual=%0d cycles expected=fewer", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: in-flight writers with their age past R1.
    typedef struct {
        int dst;
        bit wr;
        bit ld;
        int age;
    } rec_t;
    rec_t flight[$];

    int o_hold, o_bub, o_fa, o_fb, o_kill;

    function automatic void lookup(input int src, output bit stall, output int code);
        int best_age;
        bit best_ld;
        best_age = -1;
        best_ld  = 0;
        foreach (flight[i]) begin
            if (src != 0 && flight[i].wr && flight[i].dst == src &&
                (best_age < 0 || flight[i].age < best_age)) begin
                best_age = flight[i].age;
                best_ld  = flight[i].ld;
            end
        end
        if (best_age < 0) begin
            stall = 0; code = 0;
        end else if (best_age < (best_ld ? 5 : 2)) begin
            stall = 1; code = 0;
        end else begin
            stall = 0;
            code  = (best_age <= 4) ? 1 : (best_age == 5) ? 2 : 3;
        end
    endfunction

    task automatic step(input bit v, input int sa, input int sb, input int dst,
                        input bit wen, input bit ld, input bit br);
        bit sta, stb, x1v, e_kill, e_hold, e_go;
        int ca, cb;
        rec_t nxt[$];
        @(negedge clk);
        r1_vld = v; r1_src_a = sa[4:0]; r1_src_b = sb[4:0]; r1_dst = dst[4:0];
        r1_wen = wen; r1_is_load = ld; x1_br_taken = br;
        #1;
        x1v = 0;
        foreach (flight[i]) if (flight[i].age == 0) x1v = 1;
        lookup(sa, sta, ca);
        lookup(sb, stb, cb);
        e_kill = br && x1v;
        e_hold = v && !e_kill && (sta || stb);
        e_go   = v && !e_kill && !e_hold;
        o_hold = int'(front_hold); o_bub = int'(x1_bubble);
        o_fa = int'(fwd_a); o_fb = int'(fwd_b); o_kill = int'(front_kill);
        chk("R2 model hold", o_hold, int'(e_hold));
        chk("R8 model kill", o_kill, e_kill ? 7 : 0);
        chk("R4 model bubble", o_bub, int'(!e_go));
        chk("R5 model fwd_a", o_fa, e_go ? ca : 0);
        chk("R5 model fwd_b", o_fb, e_go ? cb : 0);
        foreach (flight[i]) begin
            if (flight[i].age < 6) begin
                rec_t r;
                r = flight[i];
                r.age = r.age + 1;
                nxt.push_back(r);
            end
        end
        if (e_go) begin
            rec_t r;
            r.dst = dst; r.wr = wen && (dst != 0); r.ld = ld; r.age = 0;
            nxt.push_back(r);
        end
        flight = nxt;
    endtask

    task automatic issue(input int dst, input bit wen, input bit ld);
        step(1, 0, 0, dst, wen, ld, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic consume(input int sa, input int sb, output int stalls,
                           output int fa, output int fb);
        stalls = 0;
        for (int i = 0; i < 20; i++) begin
            step(1, sa, sb, 0, 0, 0, 0);
            if (o_hold == 1) begin
                stalls++;
                chk("R4 bubble during hold", o_bub, 1);
            end else begin
                chk("R4 bubble on release", o_bub, 0);
                break;
            end
        end
        fa = o_fa; fb = o_fb;
    endtask

    initial begin
        int s, fa, fb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset hold", int'(front_hold), 0);
        chk("R1 reset kill", int'(front_kill), 0);
        chk("R1 reset bubble", int'(x1_bubble), 1);
        chk("R1 reset fwd_a", int'(fwd_a), 0);
        chk("R1 reset fwd_b", int'(fwd_b), 0);

        // R2: ALU producer at several separations
        issue(5, 1, 0); consume(5, 0, s, fa, fb);
        chk("R2 alu adjacent stalls", s, 2); chk("R5 alu adjacent code", fa, 1);
        idle(8);
        issue(6, 1, 0); idle(1); consume(0, 6, s, fa, fb);
        chk("R2 alu gap1 stalls", s, 1); chk("R5 alu gap1 code b", fb, 1);
        idle(8);
        issue(6, 1, 0); idle(2); consume(6, 0, s, fa, fb);
        chk("R2 alu gap2 stalls", s, 0);
        idle(8);

        // R3: load producer
        issue(7, 1, 1); consume(7, 0, s, fa, fb);
        chk("R3 load adjacent stalls", s, 5); chk("R5 load adjacent code", fa, 2);
        idle(8);
        issue(7, 1, 1); idle(3); consume(7, 0, s, fa, fb);
        chk("R3 load gap3 stalls", s, 2);
        idle(8);
        issue(7, 1, 1); idle(5); consume(7, 0, s, fa, fb);
        chk("R3 load gap5 stalls", s, 0); chk("R5 load gap5 code", fa, 2);
        idle(8);

        // R5: per-operand codes and W1 / aged-out
        issue(3, 1, 0); issue(4, 1, 0); idle(4); consume(3, 4, s, fa, fb);
        chk("R5 split code a", fa, 2); chk("R5 split code b", fb, 1);
        idle(8);
        issue(8, 1, 0); idle(6); consume(8, 0, s, fa, fb);
        chk("R5 writeback code", fa, 3);
        idle(8);
        issue(8, 1, 0); idle(7); consume(8, 0, s, fa, fb);
        chk("R5 retired code", fa, 0);
        idle(8);

        // R6: youngest writer wins
        issue(5, 1, 1); issue(5, 1, 0); consume(5, 0, s, fa, fb);
        chk("R6 alu over load stalls", s, 2); chk("R6 alu over load code", fa, 1);
        idle(8);
        issue(5, 1, 0); issue(5, 1, 1); consume(5, 0, s, fa, fb);
        chk("R6 load over alu stalls", s, 5); chk("R6 load over alu code", fa, 2);
        idle(8);

        // R7: non-writers and register 0
        issue(5, 0, 1); consume(5, 0, s, fa, fb);
        chk("R7 wen clear stalls", s, 0); chk("R7 wen clear code", fa, 0);
        idle(8);
        issue(0, 1, 1); consume(0, 0, s, fa, fb);
        chk("R7 reg0 stalls", s, 0); chk("R7 reg0 code", fa, 0);
        idle(8);

        // R8: taken branch in X1 kills the front; squashed writer leaves no trace
        issue(5, 1, 1);
        issue(0, 0, 0);
        step(1, 5, 0, 9, 1, 0, 1);
        chk("R8 kill vector", o_kill, 7);
        chk("R8 no hold under kill", o_hold, 0);
        chk("R8 bubble under kill", o_bub, 1);
        step(1, 9, 0, 0, 0, 0, 0);
        chk("R8 squashed no hold", o_hold, 0);
        chk("R8 squashed no code", o_fa, 0);
        chk("R8 kill not repeated", o_kill, 0);
        idle(8);

        // R9: resolution with an empty X1
        step(1, 0, 0, 0, 0, 0, 1);
        chk("R9 ignored kill", o_kill, 0);
        chk("R9 ignored bubble", o_bub, 0);
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule